// File: doc/BRIEF.md
# GF(4096) Composite-Field Multiplier

This block multiplies two 12-bit elements of GF(4096) and returns the 12-bit product one clock later. The field is built as a quadratic extension of GF(64). Each operand splits into a high 6-bit half and a low 6-bit half. Three GF(64) products combine those halves, and one more product scales by a fixed constant. This is the arithmetic element that a Reed-Solomon encoder or decoder instantiates for its field operations.

A one-bit valid input marks the cycles whose operands should be taken. The matching valid output rises in the following cycle. There is no backpressure: a new pair may be presented in every cycle. A generator mode ignores the second operand and multiplies the first operand by a fixed constant, which is 0xE01 by default. Repeated use of this mode steps through powers of the code's generator element.

Top module: `gf4096_mul`

## Requirements
- R1: When `in_valid` is high at a rising clock edge, `out_valid` is high during the next cycle and `product` holds the result for the operands sampled at that edge. When `in_valid` is low, `out_valid` is low during the next cycle.
- R2: While `rst_n` is low, and in the first cycle after reset is released, `out_valid` is 0 and `product` is 0.
- R3: If either operand is 0x000, the product is 0x000.
- R4: The element 0x001 is the identity, so a × 0x001 = a.
- R5: Multiplication is commutative: a × b = b × a.
- R6: Field arithmetic. GF(64) uses the polynomial x^6+x+1, with bit i of a 6-bit half being the coefficient of x^i. Bits [11:6] of an operand hold the high half h and bits [5:0] hold the low half l. Let c = 0x21, which is the inverse of x in GF(64). The product's high half is ah·bh ⊕ ah·bl ⊕ al·bh. Its low half is c·ah·bh ⊕ al·bl. The product places the high half at bits [11:6] and the low half at bits [5:0].
- R7: When `gen_mode` is 1 on a valid cycle, `op_b` is ignored and the product is `op_a` × 0xE01.
- R8: `product` keeps its last value on every cycle in which no valid input was taken.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Operands present this cycle |
| gen_mode | input | 1 | 1: multiply `op_a` by the generator constant, ignoring `op_b` |
| op_a | input | 12 | First operand |
| op_b | input | 12 | Second operand |
| out_valid | output | 1 | `product` was updated at the last edge |
| product | output | 12 | Registered field product |

## Verification
On each edge the block presents the previous product and captures a new operand pair at the same time. The choice between `op_b` and the generator constant is also made in that same cycle. The bench streams operands back to back with no idle cycles and toggles `gen_mode` from one cycle to the next. While in generator mode it puts misleading values on `op_b`. Each output is compared against a reference that expands the product as a polynomial over GF(64) and uses log/antilog tables, tracked one cycle behind the stimulus. Idle cycles with changed operands placed between valid ones show whether anything leaked into `product`.

// File: rtl/gf4096_mul.sv
`timescale 1ns/1ps
module gf4096_mul #(
  parameter logic [11:0] GEN_CONST = 12'hE01,
  parameter logic [5:0]  EXT_CONST = 6'h21
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        in_valid,
  input  logic        gen_mode,
  input  logic [11:0] op_a,
  input  logic [11:0] op_b,
  output logic        out_valid,
  output logic [11:0] product
);
  localparam int HW = 6;

  function automatic logic [HW-1:0] gf64_mul(input logic [HW-1:0] x, input logic [HW-1:0] y);
    logic [HW-1:0] acc;
    logic [HW-1:0] sh;
    acc = '0;
    sh  = y;
    for (int i = 0; i < HW; i++) begin
      if (x[i]) acc = acc ^ sh;
      sh = {sh[HW-2:0], 1'b0} ^ (sh[HW-1] ? 6'h03 : 6'h00);
    end
    return acc;
  endfunction

  logic [11:0]   b_sel;
  logic [HW-1:0] ah, al, bh, bl, p_ll, p_hh, hi, lo;

  assign b_sel = gen_mode ? GEN_CONST : op_b;
  assign ah    = op_a[11:HW];
  assign al    = op_a[HW-1:0];
  assign bh    = b_sel[11:HW];
  assign bl    = b_sel[HW-1:0];
  assign p_ll  = gf64_mul(al, bl);
  assign p_hh  = gf64_mul(ah, bh);
  assign hi    = gf64_mul(ah ^ al, bh ^ bl) ^ p_ll;
  assign lo    = gf64_mul(p_hh, EXT_CONST) ^ p_ll;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      product   <= '0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) product <= {hi, lo};
    end
  end

  p_valid_follows_r1: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);
  p_idle_follows_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid);
  p_zero_operand_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && (op_a == 12'h000)) |=> (product == 12'h000));
  p_identity_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !gen_mode && (op_b == 12'h001)) |=> (product == $past(op_a)));
  p_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> $stable(product));
endmodule

// File: tb/tb_gf4096_mul.sv
`timescale 1ns/1ps
module tb_gf4096_mul;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic        gen_mode = 1'b0;
  logic [11:0] op_a = '0;
  logic [11:0] op_b = '0;
  logic        out_valid;
  logic [11:0] product;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  int lg [64];
  logic [5:0] ex [63];

  logic        exp_v = 1'b0;
  logic [11:0] exp_p = '0;
  logic [11:0] last_p = '0;
  string       exp_tag = "R1";
  logic [31:0] lfsr = 32'h1D2C3B4A;

  gf4096_mul dut (.clk(clk), .rst_n(rst_n), .in_valid(in_valid), .gen_mode(gen_mode),
                  .op_a(op_a), .op_b(op_b), .out_valid(out_valid), .product(product));

  always #5 clk = ~clk;

  function automatic logic [5:0] m64(input logic [5:0] x, input logic [5:0] y);
    if (x == 0 || y == 0) return 6'd0;
    return ex[(lg[x] + lg[y]) % 63];
  endfunction

  function automatic logic [11:0] ref_mul(input logic [11:0] a, input logic [11:0] b);
    logic [5:0] hh, hl, lh, ll;
    hh = m64(a[11:6], b[11:6]);
    hl = m64(a[11:6], b[5:0]);
    lh = m64(a[5:0], b[11:6]);
    ll = m64(a[5:0], b[5:0]);
    return {hh ^ hl ^ lh, m64(hh, 6'h21) ^ ll};
  endfunction

  function automatic logic [11:0] rnd();
    lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
    return lfsr[11:0] ^ lfsr[27:16];
  endfunction

  task automatic check(input bit ok, input string tag, input logic [11:0] act, input logic [11:0] expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %03h expected %03h", tag, act, expv);
    end
  endtask

  task automatic drive(input logic v, input logic g, input logic [11:0] a, input logic [11:0] b,
                       input logic [11:0] expect_val, input string tag);
    @(negedge clk);
    check(out_valid == exp_v, "R1 out_valid", {11'd0, out_valid}, {11'd0, exp_v});
    if (exp_v) check(product == exp_p, exp_tag, product, exp_p);
    else       check(product == last_p, "R8 hold", product, last_p);
    in_valid = v; gen_mode = g; op_a = a; op_b = b;
    exp_v = v;
    if (v) begin exp_p = expect_val; last_p = expect_val; exp_tag = tag; end
  endtask

  initial begin
    #(200000 * 10);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [5:0] e;
    e = 6'd1;
    lg[0] = 0;
    for (int i = 0; i < 63; i++) begin
      ex[i] = e; lg[e] = i;
      e = {e[4:0], 1'b0} ^ (e[5] ? 6'h03 : 6'h00);
    end

    repeat (3) @(negedge clk);
    check(out_valid == 1'b0, "R2 out_valid in reset", {11'd0, out_valid}, 12'd0);
    check(product == 12'd0, "R2 product in reset", product, 12'd0);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(out_valid == 1'b0, "R2 out_valid after reset", {11'd0, out_valid}, 12'd0);
    check(product == 12'd0, "R2 product after reset", product, 12'd0);

    // R4: identity, both operand positions
    for (int a = 0; a < 4096; a++) drive(1, 0, 12'(a), 12'h001, 12'(a), "R4 a*1");
    for (int a = 0; a < 4096; a += 7) drive(1, 0, 12'h001, 12'(a), 12'(a), "R4 1*a");
    // R3: zero in either position
    for (int a = 0; a < 4096; a += 3) drive(1, 0, 12'(a), 12'h000, 12'h000, "R3 a*0");
    for (int a = 0; a < 4096; a += 5) drive(1, 0, 12'h000, 12'(a), 12'h000, "R3 0*a");
    // R7: generator mode, op_b holding misleading values, alternating with plain mode
    for (int a = 0; a < 4096; a++) begin
      logic [11:0] bb;
      bb = rnd();
      if (a % 2 == 0) drive(1, 1, 12'(a), bb, ref_mul(12'(a), 12'hE01), "R7 gen mode");
      else            drive(1, 0, 12'(a), bb, ref_mul(12'(a), bb), "R6 plain");
    end
    // R7: walk powers of the generator
    begin
      logic [11:0] g;
      g = 12'h001;
      for (int k = 0; k < 200; k++) begin
        drive(1, 1, g, 12'hFFF, ref_mul(g, 12'hE01), "R7 generator power");
        g = ref_mul(g, 12'hE01);
      end
    end
    // R6: random pairs with idle gaps; R8 checked during idles with changed operands
    for (int k = 0; k < 6000; k++) begin
      logic [11:0] a, b;
      a = rnd(); b = rnd();
      if (k % 5 == 4) drive(0, k[3], a, b, 12'h000, "R8 idle");
      else            drive(1, 0, a, b, ref_mul(a, b), "R6 random");
    end
    // R5: commutativity
    for (int k = 0; k < 3000; k++) begin
      logic [11:0] a, b, p;
      a = rnd(); b = rnd(); p = ref_mul(a, b);
      drive(1, 0, a, b, p, "R5 a*b");
      drive(1, 0, b, a, p, "R5 b*a");
    end
    // R1: trailing idle cycles
    drive(0, 0, 12'h5A5, 12'hA5A, 12'h000, "R1 idle");
    drive(0, 0, 12'h123, 12'h456, 12'h000, "R1 idle");
    drive(0, 0, 12'h000, 12'h000, 12'h000, "R1 idle");

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule